// File: doc/BRIEF.md
# DRAM Controller Configuration Register File

This block is the software-visible register set of a DRAM controller. A bus master reaches it through a plain word-wide port inside a 4 KB byte window: one address, one write strobe, write data and read data. A protection word guards every other register. Only one exact 32-bit key value opens it, and any other value written there closes it again. While the block is closed, writes to the rest of the register set are discarded.

A few registers do not store exactly what is written. The configuration word always carries hardware-owned fields: a controller generation code, a graphics aperture code, a DRAM capacity code taken from a build parameter and, on the older generation only, an initialisation-done flag. Software cannot clear these fields. The PHY status word and the ECC self-test word have individual bits forced on every write, so the controller always looks idle, locked and passed. The generation, the capacity and the read timing (combinational or one register stage) are chosen by parameters.

Top module: `dram_cfg_regfile`

## Requirements
- R1: On reset every register reads 0, except the configuration word at byte offset 0x04, which reads its fixed value.
- R2: Writing 0xFC600309 to byte offset 0x00 makes that word read 1 (open). Writing any other value there makes it read 0 (closed). This word can be written at any time.
- R3: While offset 0x00 reads 0, a write to any other offset leaves every register unchanged.
- R4: An access whose byte address has bits 1:0 not both zero, or whose word index (address bits 11:2) is at or above the register count, reads 0 and writes nothing.
- R5: A write to the configuration word stores the write data with bits 31:28, 19:14, 6 and 3:2 cleared, ORed with the fixed value. The fixed value is the generation code in bits 31:28 (1 for generation 0, 3 for generation 1), 2'b11 in bits 3:2, bit 19 set for generation 0 only, and the capacity code in bits 1:0.
- R6: The capacity code is 0..3 for 128/256/512/1024 MB on generation 0 and for 256/512/1024/2048 MB on generation 1. Any other size gives the 512 MB code (2 on generation 0, 1 on generation 1).
- R7: A write to the PHY status word at offset 0x60 stores the data with bit 0 cleared. On generation 1, bit 4 is also set.
- R8: A write to the ECC test word at offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R9: With READ_REG=0 the read data follows the address in the same cycle. With READ_REG=1 it appears after the next clock edge.
- R10: While open, every other in-range word stores and returns the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The bench builds three copies of the block on one shared bus. The first is generation 1 at 2048 MB with combinational reads, which covers the top capacity code and the forced PLL-lock bit. The second is generation 0 with an unsupported 300 MB size and a registered read port, which covers the capacity fallback, the forced initialisation-done bit and the one-cycle read latency. The third is generation 1 at 256 MB, which shows capacity code 0 in the configuration word after reset.

// File: rtl/dcr_pkg.sv
// Package: shared constants and constant functions for the DRAM
// controller register file. Assumes 32-bit registers and word addressing.
package dcr_pkg;
    typedef logic [31:0] word_t;

    localparam word_t UNLOCK_KEY   = 32'hFC60_0309;
    localparam word_t CONF_RO_MASK = 32'hF00F_C04C;
    localparam int    IDX_PROT     = 0;
    localparam int    IDX_CONF     = 1;
    localparam int    IDX_PHY      = 24;
    localparam int    IDX_ECC      = 28;

    // Capacity code for a generation and a size in MB, falling back to 512 MB.
    function automatic logic [1:0] size_code(int gen, int mb);
        if (gen == 0) begin
            case (mb)
                128:     return 2'd0;
                256:     return 2'd1;
                512:     return 2'd2;
                1024:    return 2'd3;
                default: return 2'd2;
            endcase
        end else begin
            case (mb)
                256:     return 2'd0;
                512:     return 2'd1;
                1024:    return 2'd2;
                2048:    return 2'd3;
                default: return 2'd1;
            endcase
        end
    endfunction

    // Hardware-owned part of the configuration word.
    function automatic word_t fixed_conf(int gen, int mb);
        word_t v;
        v = 32'h0000_000C | {30'b0, size_code(gen, mb)};
        if (gen == 0) v = v | 32'h1008_0000;
        else          v = v | 32'h3000_0000;
        return v;
    endfunction
endpackage

// File: rtl/dcr_decode.sv
// Module: splits a byte address into a word index and a hit flag.
// Assumes only whole-word accesses are legal; misaligned ones never hit.
module dcr_decode #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-3:0] idx,
    output logic              hit
);
    localparam int WIDX_W = ADDR_W - 2;

    // Word index plus alignment and range qualification.
    always_comb begin
        idx = addr[ADDR_W-1:2];
        hit = (addr[1:0] == 2'b00) && ({1'b0, idx} < (WIDX_W + 1)'(NUM_WORDS));
    end
endmodule

// File: rtl/dcr_shaper.sv
// Module: applies each register's write rules (read-only masking and
// forced bits) to raw write data. Purely combinational. The lock is
// handled by the caller.
module dcr_shaper
    import dcr_pkg::*;
#(
    parameter int    WIDX_W = 10,
    parameter int    GEN    = 1,
    parameter word_t FIXED  = 32'h0
) (
    input  logic [WIDX_W-1:0] idx,
    input  word_t             wdata,
    output word_t             shaped
);
    localparam word_t PHY_SET = (GEN == 1) ? 32'h0000_0010 : 32'h0;

    // Per-register value to store for this write.
    always_comb begin
        if (idx == WIDX_W'(IDX_CONF))
            shaped = (wdata & ~CONF_RO_MASK) | FIXED;
        else if (idx == WIDX_W'(IDX_PHY))
            shaped = (wdata & ~32'h1) | PHY_SET;
        else if (idx == WIDX_W'(IDX_ECC))
            shaped = (wdata | 32'h0000_1000) & ~32'h0000_2000;
        else
            shaped = wdata;
    end
endmodule

// File: rtl/dcr_rdport.sv
// Module: read mux over the register array, either combinational or
// with one register stage as chosen by READ_REG. A miss reads zero.
module dcr_rdport
    import dcr_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5,
    parameter bit READ_REG  = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NUM_WORDS-1:0][31:0]  regs,
    output word_t                       rdata
);
    word_t sel;

    // Select the addressed word, or zero on a miss.
    always_comb sel = hit ? regs[idx] : '0;

    generate
        if (READ_REG) begin : g_reg
            word_t rdata_q;
            // Register the selected word for a one-cycle read.
            always_ff @(posedge clk) begin
                if (!rst_n) rdata_q <= '0;
                else        rdata_q <= sel;
            end
            assign rdata = rdata_q;

            assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |=> (rdata == 32'h0));
            assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> (rdata == $past(regs[idx])));
        end else begin : g_comb
            assign rdata = sel;

            assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |-> (rdata == 32'h0));
        end
    endgenerate
endmodule

// File: rtl/dram_cfg_regfile.sv
// Module: key-locked configuration/status register file of a DRAM
// controller. Word 0 is the protection word; all other writes need it
// open. Assumes one access per cycle on a single shared address.
module dram_cfg_regfile
    import dcr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 32,
    parameter int GEN       = 1,
    parameter int SIZE_MB   = 512,
    parameter bit READ_REG  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int    WIDX_W = ADDR_W - 2;
    localparam int    IDX_W  = $clog2(NUM_WORDS);
    localparam word_t FIXED  = fixed_conf(GEN, SIZE_MB);

    logic [NUM_WORDS-1:0][31:0] regs_q;
    logic [WIDX_W-1:0]          widx;
    logic                       hit;
    logic                       wr_hit;
    logic                       unlocked;
    word_t                      shaped;

    dcr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr(bus_addr), .idx(widx), .hit(hit)
    );

    dcr_shaper #(.WIDX_W(WIDX_W), .GEN(GEN), .FIXED(FIXED)) u_shp (
        .idx(widx), .wdata(bus_wdata), .shaped(shaped)
    );

    // Qualified write strobe and lock state.
    always_comb begin
        wr_hit   = bus_we && hit;
        unlocked = regs_q[IDX_PROT][0];
    end

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
            if (g == IDX_PROT) begin : g_prot
                // Protection word: key compare, always writable.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs_q[g] <= '0;
                    else if (wr_hit && widx == WIDX_W'(g))
                        regs_q[g] <= {31'b0, bus_wdata == UNLOCK_KEY};
                end
            end else begin : g_data
                // Ordinary word: shaped write while open.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs_q[g] <= (g == IDX_CONF) ? FIXED : '0;
                    else if (wr_hit && unlocked && widx == WIDX_W'(g))
                        regs_q[g] <= shaped;
                end
            end
        end
    endgenerate

    dcr_rdport #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .READ_REG(READ_REG)) u_rd (
        .clk(clk), .rst_n(rst_n), .hit(hit), .idx(widx[IDX_W-1:0]),
        .regs(regs_q), .rdata(bus_rdata)
    );

    assert_key_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx == WIDX_W'(IDX_PROT)) |=>
        (regs_q[IDX_PROT] == {31'b0, $past(bus_wdata) == UNLOCK_KEY}));

    assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx != WIDX_W'(IDX_PROT) && !unlocked) |=> $stable(regs_q));

    assert_conf_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q[IDX_CONF] & CONF_RO_MASK) == (FIXED & CONF_RO_MASK)) &&
        ((regs_q[IDX_CONF] & FIXED) == FIXED));

    assert_phy_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && unlocked && widx == WIDX_W'(IDX_PHY)) |=>
        (!regs_q[IDX_PHY][0] && (GEN == 0 || regs_q[IDX_PHY][4])));

    assert_ecc_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && unlocked && widx == WIDX_W'(IDX_ECC)) |=>
        (regs_q[IDX_ECC][13:12] == 2'b01));
endmodule

// File: tb/dram_cfg_regfile_test.sv
module dram_cfg_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'hFC60_0309;
    localparam logic [31:0] RO  = 32'hF00F_C04C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_a, rd_b, rd_c;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m [2][32];   // [0]: uut (gen 1, 2048 MB), [1]: uut_alt (gen 0, 300 MB)

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cfg_regfile #(.GEN(1), .SIZE_MB(2048), .READ_REG(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rd_a));
    dram_cfg_regfile #(.GEN(0), .SIZE_MB(300), .READ_REG(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b));
    dram_cfg_regfile #(.GEN(1), .SIZE_MB(256), .READ_REG(1'b0)) uut_small (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rd_c));

    function automatic int gen_of(int k);
        return (k == 0) ? 1 : 0;
    endfunction

    // Fixed configuration value from R5/R6.
    function automatic logic [31:0] fixed_of(int gen, int mb);
        logic [31:0] v;
        int code;
        if (gen == 0) code = (mb == 128) ? 0 : (mb == 256) ? 1 : (mb == 512) ? 2 : (mb == 1024) ? 3 : 2;
        else          code = (mb == 256) ? 0 : (mb == 512) ? 1 : (mb == 1024) ? 2 : (mb == 2048) ? 3 : 1;
        v = 32'hC | 32'(code);
        v = v | ((gen == 0) ? 32'h1008_0000 : 32'h3000_0000);
        return v;
    endfunction

    function automatic logic [31:0] fixed_k(int k);
        return (k == 0) ? fixed_of(1, 2048) : fixed_of(0, 300);
    endfunction

    // Stored value after an open write (R5, R7, R8, R10).
    function automatic logic [31:0] shape(int k, int idx, logic [31:0] d);
        if (idx == 1)  return (d & ~RO) | fixed_k(k);
        if (idx == 24) return (d & ~32'h1) | ((gen_of(k) == 1) ? 32'h10 : 32'h0);
        if (idx == 28) return (d | 32'h1000) & ~32'h2000;
        return d;
    endfunction

    function automatic logic addr_hit(logic [11:0] a);
        return (a[1:0] == 2'b00) && (a[11:2] < 10'd32);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 32; i++) m[k][i] = '0;
            m[k][1] = fixed_k(k);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        if (addr_hit(a)) begin
            for (int k = 0; k < 2; k++) begin
                if (a[11:2] == 10'd0) m[k][0] = (d == KEY) ? 32'h1 : 32'h0;
                else if (m[k][0] == 32'h1) m[k][a[6:2]] = shape(k, int'(a[6:2]), d);
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(string req, logic [11:0] a);
        logic [31:0] ea, eb;
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        ea = addr_hit(a) ? m[0][a[6:2]] : 32'h0;
        eb = addr_hit(a) ? m[1][a[6:2]] : 32'h0;
        #1;
        check(req, rd_a, ea);
        @(posedge clk);
        #1;
        check(req, rd_b, eb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word, both variants.
        for (int i = 0; i < 32; i++) rd("R1", 12'(i * 4));
        // R6: capacity codes (2048 MB -> 3, 300 MB -> fallback 2, 256 MB -> 0).
        @(negedge clk); bus_addr = 12'h004; #1;
        check("R6", rd_a, 32'h3000_000F);
        check("R6", rd_c, 32'h3000_000C);
        @(posedge clk); #1;
        check("R6", rd_b, 32'h1008_000E);

        // R3: closed after reset, writes dropped.
        wr(12'h014, 32'h1234_5678);
        rd("R3", 12'h014);
        wr(12'h004, 32'hFFFF_FFFF);
        rd("R3", 12'h004);

        // R2: wrong key keeps closed, right key opens.
        wr(12'h000, KEY ^ 32'h1);
        rd("R2", 12'h000);
        wr(12'h000, KEY);
        rd("R2", 12'h000);

        // R10: plain storage.
        wr(12'h014, 32'hDEAD_BEEF);
        rd("R10", 12'h014);
        wr(12'h07C, 32'h0F0F_A5A5);
        rd("R10", 12'h07C);

        // R5: configuration masking.
        wr(12'h004, 32'hFFFF_FFFF);
        rd("R5", 12'h004);
        wr(12'h004, 32'h0000_0000);
        rd("R5", 12'h004);
        wr(12'h004, 32'h0FF0_3F33);
        rd("R5", 12'h004);

        // R7: PHY status forcing.
        wr(12'h060, 32'hFFFF_FFFF);
        rd("R7", 12'h060);
        wr(12'h060, 32'h0000_0001);
        rd("R7", 12'h060);

        // R8: ECC test forcing.
        wr(12'h070, 32'h0000_2000);
        rd("R8", 12'h070);
        wr(12'h070, 32'hFFFF_FFFF);
        rd("R8", 12'h070);

        // R4: out of range and misaligned.
        rd("R4", 12'h080);
        wr(12'h080, 32'h0000_0000);
        rd("R4", 12'h000);
        rd("R4", 12'h015);
        wr(12'h016, 32'h5555_5555);
        rd("R4", 12'h014);
        wr(12'hFFC, 32'h0000_0000);
        rd("R4", 12'hFFC);
        rd("R4", 12'h000);

        // R9: combinational vs registered timing.
        rd("R9", 12'h080);
        @(negedge clk);
        bus_addr = 12'h014; #1;
        check("R9", rd_a, 32'hDEAD_BEEF);
        check("R9", rd_b, 32'h0);
        @(posedge clk); #1;
        check("R9", rd_b, 32'hDEAD_BEEF);

        // R3: lock again, writes dropped everywhere.
        wr(12'h000, 32'h0);
        wr(12'h014, 32'h0);
        rd("R3", 12'h014);
        wr(12'h070, 32'h0);
        rd("R3", 12'h070);

        // Random mix against the model (R10 and friends).
        for (int n = 0; n < 600; n++) begin
            r = $urandom;
            if (r[3:0] == 4'd0)      wr(12'h000, KEY);
            else if (r[3:0] == 4'd1) wr(12'h000, $urandom);
            else begin
                logic [11:0] a;
                case (r[6:4])
                    3'd0: a = 12'h004;
                    3'd1: a = 12'h060;
                    3'd2: a = 12'h070;
                    3'd3: a = 12'($urandom_range(32, 1023) * 4);
                    default: a = 12'($urandom_range(0, 31) * 4);
                endcase
                if (r[7]) wr(a, $urandom);
                else      rd("R10", a);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule